// File: doc/BRIEF.md
# Event-to-Counter Affinity Allocator

This block gives out hardware event counters to event requests. Each request carries an 8-bit event code. Each event may only run on some of the ten counters, and the set of counters it may use differs from event to event. The allocator looks up that set and removes the counters that are already in use. From what remains it grants the lowest-numbered counter and marks that counter as taken, all in one operation. If nothing remains, the request is refused and the caller should retry later. A release request frees a counter so that it can be granted again.

Requests and responses use a valid/ready handshake. Up to one operation (allocate or release) is accepted per cycle. The response for an accepted operation appears in the next cycle and stays until the consumer takes it.

Top module: `ctr_alloc`

## Requirements
- R1: An event code with no special rule may use counters 2..9 only, never counter 0 or 1.
- R2: Event codes 0x01, 0x96, 0x97, 0x9a, 0x9b and 0x9f may use counter 7 and no other.
- R3: Event code 0x02 may use counter 0 and counters 2..9 (not counter 1).
- R4: Event code 0x8c may use counters 1 and 7 only.
- R5: Event codes 0x8d..0x90, 0x93..0x95, 0x98, 0x99, 0x9c, 0xbf..0xc1, 0xc4..0xc6, 0xc8, 0xca and 0xcb may use counters 5, 6 and 7 only.
- R6: Event codes 0xf5, 0xf6, 0xf7 and 0xfd may use counters 2, 4 and 6 only. Event code 0xf8 may use counters 2..7.
- R7: A successful allocation returns the lowest-numbered counter that is both allowed and free, with rsp_fail = 0. That counter counts as used from the next operation on.
- R8: When no allowed counter is free, the response has rsp_fail = 1 and rsp_index = 0, and the set of used counters does not change.
- R9: A release (req_release = 1) frees counter req_index. Its response echoes req_index with rsp_fail = 0. Releasing a counter that is already free, or an index of 10 or more, has no effect on later allocations.
- R10: A request is accepted when req_valid and req_ready are both high. req_ready = !rsp_valid || rsp_ready. The response is valid in the cycle after acceptance and holds its index and fail flag steady while rsp_ready is low.
- R11: A synchronous active-high reset frees all counters and clears rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_release | input | 1 | 1 = release req_index, 0 = allocate for req_event |
| req_event | input | 8 | Event code to place |
| req_index | input | 4 | Counter index to release |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_index | output | 4 | Granted counter (allocate) or echoed index (release) |
| rsp_fail | output | 1 | Allocation refused, retry later |

## Verification
The bench uses the default configuration: ten counters and 8-bit event codes. With only ten counters, every restricted event class can be driven to exhaustion in a few requests. This exposes the ascending-order choice among partly occupied sets, such as 2/4/6 with counter 2 already taken. It also exposes failures that must leave the used set untouched. A randomized phase with response backpressure mixes allocations and releases across all event classes, so that the handshake is checked while the used set shifts.

// File: rtl/ctr_alloc_pkg.sv
package ctr_alloc_pkg;
  localparam int NUM_CTR = 10;
  localparam int EV_W    = 8;
  localparam int IDX_W   = $clog2(NUM_CTR + 6);

  // Named counter groups (bit i = counter i may be used)
  localparam logic [NUM_CTR-1:0] GRP_DEFAULT = 10'b11_1111_1100;
  localparam logic [NUM_CTR-1:0] GRP_ONLY7   = 10'b00_1000_0000;
  localparam logic [NUM_CTR-1:0] GRP_CYCLES  = 10'b11_1111_1101;
  localparam logic [NUM_CTR-1:0] GRP_INSTR   = 10'b00_1000_0010;
  localparam logic [NUM_CTR-1:0] GRP_567     = 10'b00_1110_0000;
  localparam logic [NUM_CTR-1:0] GRP_EVEN246 = 10'b00_0101_0100;
  localparam logic [NUM_CTR-1:0] GRP_2TO7    = 10'b00_1111_1100;

  function automatic logic [NUM_CTR-1:0] allowed_mask(input logic [EV_W-1:0] ev);
    logic [NUM_CTR-1:0] m;
    case (ev)
      8'h01, 8'h96, 8'h97, 8'h9a, 8'h9b, 8'h9f: m = GRP_ONLY7;
      8'h02:                                    m = GRP_CYCLES;
      8'h8c:                                    m = GRP_INSTR;
      8'h8d, 8'h8e, 8'h8f, 8'h90,
      8'h93, 8'h94, 8'h95, 8'h98, 8'h99, 8'h9c,
      8'hbf, 8'hc0, 8'hc1, 8'hc4, 8'hc5, 8'hc6,
      8'hc8, 8'hca, 8'hcb:                      m = GRP_567;
      8'hf5, 8'hf6, 8'hf7, 8'hfd:               m = GRP_EVEN246;
      8'hf8:                                    m = GRP_2TO7;
      default:                                  m = GRP_DEFAULT;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ctr_affinity_lut.sv
module ctr_affinity_lut
  import ctr_alloc_pkg::*;
#(
  parameter int N   = NUM_CTR,
  parameter int EVW = EV_W
) (
  input  logic [EVW-1:0] event_code,
  output logic [N-1:0]   allow
);
  localparam int COPY_W = (N < NUM_CTR) ? N : NUM_CTR;

  logic [NUM_CTR-1:0] full;
  always_comb full = allowed_mask(EV_W'(event_code));

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i < COPY_W) begin : g_map
        assign allow[i] = full[i];
      end else begin : g_none
        assign allow[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/ctr_first_free.sv
module ctr_first_free #(
  parameter int N    = 10,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    cand,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] take;

  assign seen[0] = 1'b0;
  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      assign take[i]   = cand[i] & ~seen[i];
      assign seen[i+1] = seen[i] | cand[i];
    end
  endgenerate

  assign hit = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (take[i]) idx = idx | IDXW'(i);
    end
  end
endmodule

// File: rtl/ctr_used_mask.sv
module ctr_used_mask #(
  parameter int N    = 10,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [IDXW-1:0] set_idx,
  input  logic            clr_en,
  input  logic [IDXW-1:0] clr_idx,
  output logic [N-1:0]    used
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) begin
          used[i] <= 1'b0;
        end else if (set_en && set_idx == IDXW'(i)) begin
          used[i] <= 1'b1;
        end else if (clr_en && clr_idx == IDXW'(i)) begin
          used[i] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ctr_alloc.sv
module ctr_alloc
  import ctr_alloc_pkg::*;
#(
  parameter int N    = NUM_CTR,
  parameter int EVW  = EV_W,
  parameter int IDXW = IDX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_release,
  input  logic [EVW-1:0]  req_event,
  input  logic [IDXW-1:0] req_index,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [IDXW-1:0] rsp_index,
  output logic            rsp_fail
);
  logic [N-1:0]    used;
  logic [N-1:0]    allow;
  logic [N-1:0]    cand;
  logic            hit;
  logic [IDXW-1:0] pick;
  logic            accept;
  logic            do_alloc;
  logic            do_free;

  logic            rsp_valid_q;
  logic [IDXW-1:0] rsp_index_q;
  logic            rsp_fail_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign do_alloc  = accept && !req_release && hit;
  assign do_free   = accept && req_release;
  assign cand      = allow & ~used;

  ctr_affinity_lut #(.N(N), .EVW(EVW)) u_lut (
    .event_code (req_event),
    .allow      (allow)
  );

  ctr_first_free #(.N(N), .IDXW(IDXW)) u_pick (
    .cand (cand),
    .hit  (hit),
    .idx  (pick)
  );

  ctr_used_mask #(.N(N), .IDXW(IDXW)) u_used (
    .clk     (clk),
    .rst     (rst),
    .set_en  (do_alloc),
    .set_idx (pick),
    .clr_en  (do_free),
    .clr_idx (req_index),
    .used    (used)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_index_q <= '0;
      rsp_fail_q  <= 1'b0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      if (req_release) begin
        rsp_index_q <= req_index;
        rsp_fail_q  <= 1'b0;
      end else begin
        rsp_index_q <= hit ? pick : '0;
        rsp_fail_q  <= !hit;
      end
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_index = rsp_index_q;
  assign rsp_fail  = rsp_fail_q;
endmodule

// File: rtl/ctr_alloc_chk.sv
module ctr_alloc_chk #(
  parameter int N    = 10,
  parameter int EVW  = 8,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_release,
  input logic [EVW-1:0]  req_event,
  input logic [IDXW-1:0] req_index,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [IDXW-1:0] rsp_index,
  input logic            rsp_fail
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_rsp_follows_accept_r10: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);

  p_rsp_held_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_index) && $stable(rsp_fail)));

  p_stall_blocks_req_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_grant_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    $past(acc && !req_release) |-> (rsp_fail || rsp_index < IDXW'(N)));

  p_release_never_fails_r9: assert property (@(posedge clk) disable iff (rst)
    $past(acc && req_release) |-> (!rsp_fail && rsp_index == $past(req_index)));

  p_only7_grant_r2: assert property (@(posedge clk) disable iff (rst)
    $past(acc && !req_release && req_event == EVW'(8'h01)) |-> (rsp_fail || rsp_index == IDXW'(7)));

  p_fail_index_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fail) |-> rsp_index == '0);

  p_idle_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);
endmodule

bind ctr_alloc ctr_alloc_chk #(.N(N), .EVW(EVW), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_release (req_release),
  .req_event   (req_event),
  .req_index   (req_index),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_index   (rsp_index),
  .rsp_fail    (rsp_fail)
);

// File: tb/tb_ctr_alloc.sv
module tb_ctr_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_release = 1'b0;
  logic [7:0] req_event = '0;
  logic [3:0] req_index = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [3:0] rsp_index;
  logic       rsp_fail;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_alloc dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_release(req_release), .req_event(req_event), .req_index(req_index),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_index(rsp_index), .rsp_fail(rsp_fail)
  );

  // Behavioural reference: which counters an event may use
  function automatic bit may_use(int ev, int c);
    int only7[$]  = '{8'h01, 8'h96, 8'h97, 8'h9a, 8'h9b, 8'h9f};
    int br[$]     = '{8'h8d, 8'h8e, 8'h8f, 8'h90, 8'h93, 8'h94, 8'h95, 8'h98, 8'h99,
                      8'h9c, 8'hbf, 8'hc0, 8'hc1, 8'hc4, 8'hc5, 8'hc6, 8'hc8, 8'hca, 8'hcb};
    int even3[$]  = '{8'hf5, 8'hf6, 8'hf7, 8'hfd};
    foreach (only7[k]) if (only7[k] == ev) return c == 7;
    foreach (br[k])    if (br[k] == ev)    return c >= 5 && c <= 7;
    foreach (even3[k]) if (even3[k] == ev) return c == 2 || c == 4 || c == 6;
    if (ev == 8'h02) return c == 0 || c >= 2;
    if (ev == 8'h8c) return c == 1 || c == 7;
    if (ev == 8'hf8) return c >= 2 && c <= 7;
    return c >= 2;
  endfunction

  function automatic string class_tag(int ev);
    if (may_use(ev, 7) && !may_use(ev, 6) && !may_use(ev, 1)) return "R2";
    if (ev == 8'h02) return "R3,R7";
    if (ev == 8'h8c) return "R4,R7";
    if (may_use(ev, 5) && !may_use(ev, 4)) return "R5,R7";
    if (!may_use(ev, 8) && may_use(ev, 2)) return "R6,R7";
    return "R1,R7";
  endfunction

  // Reference model state
  bit    used_m [NC];
  bit    exp_valid = 0;
  int    exp_index = 0;
  bit    exp_fail  = 0;
  string exp_tag   = "R11";

  always @(posedge clk) begin
    if (rst) begin
      foreach (used_m[c]) used_m[c] = 0;
      exp_valid = 0;
      exp_tag   = "R11";
      started   = 1;
    end else begin
      bit acc;
      acc = req_valid && (!exp_valid || rsp_ready);
      if (acc) begin
        exp_valid = 1;
        if (req_release) begin
          exp_index = req_index;
          exp_fail  = 0;
          exp_tag   = "R9";
          if (req_index < NC) used_m[req_index] = 0;
        end else begin
          int got;
          got = -1;
          for (int c = 0; c < NC; c++)
            if (got < 0 && may_use(req_event, c) && !used_m[c]) got = c;
          if (got < 0) begin
            exp_index = 0; exp_fail = 1; exp_tag = "R8";
          end else begin
            exp_index = got; exp_fail = 0; used_m[got] = 1;
            exp_tag = class_tag(req_event);
          end
        end
      end else if (rsp_ready) begin
        exp_valid = 0;
      end
    end
  end

  // Compare on every clock, half a period after the edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (rsp_valid !== exp_valid) begin
        fails++;
        $display("FAIL %s,R10 rsp_valid actual=%0b expected=%0b", exp_tag, rsp_valid, exp_valid);
      end
      if (!rst) begin
        checks++;
        if (req_ready !== (!exp_valid || rsp_ready)) begin
          fails++;
          $display("FAIL R10 req_ready actual=%0b expected=%0b", req_ready, (!exp_valid || rsp_ready));
        end
      end
      if (exp_valid && rsp_valid) begin
        checks++;
        if (rsp_index !== 4'(exp_index) || rsp_fail !== exp_fail) begin
          fails++;
          $display("FAIL %s response actual=(idx %0d fail %0b) expected=(idx %0d fail %0b)",
                   exp_tag, rsp_index, rsp_fail, exp_index, exp_fail);
        end
      end
    end
  end

  task automatic op(input bit rel, input int ev, input int idx);
    @(negedge clk);
    req_valid   = 1;
    req_release = rel;
    req_event   = 8'(ev);
    req_index   = 4'(idx);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic alloc(input int ev); op(0, ev, 0); endtask
  task automatic free(input int idx); op(1, 0, idx); endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                       // R11 idle state checked by monitor
    alloc(8'h02); alloc(8'h02);    // R3: 0 then 2
    alloc(8'h8c); alloc(8'h8c);    // R4: 1 then 7
    alloc(8'h8c);                  // R8: fails
    free(7);
    alloc(8'h01);                  // R2: 7
    alloc(8'h97);                  // R2/R8: fails
    alloc(8'h8d); alloc(8'h90);    // R5: 5, 6
    alloc(8'hcb);                  // R5/R8: fails
    free(4); free(12);             // R9: no effect
    alloc(8'hf5);                  // R6: 4
    alloc(8'hfd);                  // R6/R8: fails
    alloc(8'hf8); alloc(8'hf8);    // R6: 3, then fail
    alloc(8'h10); alloc(8'h10); alloc(8'h10); // R1: 8, 9, fail
    for (int c = 0; c < NC; c++) free(c);
    // R10: backpressure on the response
    @(negedge clk); rsp_ready = 0;
    alloc(8'h02);
    repeat (3) @(negedge clk);
    rsp_ready = 1;
    // R11: reset mid-run frees everything
    alloc(8'h02);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    alloc(8'h02);                  // 0 again
    // Randomised mix with backpressure (R7, R9, R10)
    for (int n = 0; n < 400; n++) begin
      int evs[10] = '{8'h01, 8'h02, 8'h8c, 8'h8d, 8'hc5, 8'hf5, 8'hf8, 8'h10, 8'h9f, 8'hfd};
      @(negedge clk);
      rsp_ready   = ($urandom_range(0, 3) != 0);
      req_valid   = ($urandom_range(0, 1) != 0);
      req_release = ($urandom_range(0, 2) == 0);
      req_event   = 8'(evs[$urandom_range(0, 9)]);
      req_index   = 4'($urandom_range(0, 11));
    end
    @(negedge clk); req_valid = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule